// File: doc/BRIEF.md
# FPGA configuration load sequencer

This block loads a configuration image into a slave FPGA that has a byte-wide parallel configuration port. A start command gives a byte count and a flag saying whether a configuration target is fitted. If a target is fitted, the sequencer raises an optional enable output and releases the open-drain INIT line. It then pulses the active-low PROGRAM output for a fixed number of cycles and waits for the slave to pull INIT high, which means its configuration memory is clear. Next it copies the commanded number of bytes from a valid/ready byte stream onto the data port, one write strobe per byte. Last, it waits for DONE to rise.

Each wait has its own poll limit. The sequence ends with a one-cycle done pulse and a 2-bit result code: 0 for success, 1 for no target, 2 when INIT never rose and 3 when DONE never rose. INIT and DONE are synchronised with two flops before they are used. After reset, INIT is held low, which delays the slave's power-on configuration until the first load releases it.

Top module: `cfg_loader`

## Requirements
- R1: A start with the target-present flag clear ends in the next cycle with a done pulse and result code 1. PROGRAM stays high, enable stays low and INIT hold is unchanged.
- R2: busy is high from the cycle after an accepted start until the done pulse, and falls in the cycle after it. The done pulse lasts exactly one cycle.
- R3: With HAS_ENABLE set, the enable output is high from the cycle after a start with a target until the end of the DONE wait. It is low in the done-pulse cycle whatever the result.
- R4: INIT hold (init_hold_o = 1 drives INIT low) is 1 after reset. It becomes 0 in the cycle after a start with a target, one cycle before PROGRAM goes low, and it is never 1 while PROGRAM is low.
- R5: PROGRAM is low for exactly PROG_LOW_CYC consecutive cycles per load. The default is 20.
- R6: If synchronised INIT stays low, the done pulse comes INIT_LIMIT cycles after the first cycle with PROGRAM high. It carries result code 2, and no write strobe is issued.
- R7: Once INIT reads high, exactly size_i bytes are written. wr_o marks each byte accepted on the stream (s_valid_i and s_ready_o) and wr_data_o carries it in stream order. s_ready_o is high only in the data phase.
- R8: If DONE stays low after the last strobe, the done pulse comes DONE_LIMIT+1 cycles after the strobe cycle, with result code 3.
- R9: If DONE reads high within the limit, the done pulse carries result code 0.
- R10: A start while busy is high has no effect: no second done pulse follows and no second PROGRAM pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled when idle |
| present_i | input | 1 | Configuration target fitted |
| size_i | input | SIZE_W | Number of image bytes |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| result_o | output | 2 | Result code, valid with done_o |
| en_o | output | 1 | Target enable |
| prog_n_o | output | 1 | PROGRAM, active low |
| init_hold_o | output | 1 | 1 drives the open-drain INIT line low |
| init_i | input | 1 | INIT line level |
| cfg_done_i | input | 1 | DONE line level |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_ready_o | output | 1 | Stream ready (data phase only) |
| wr_o | output | 1 | Data-port write strobe |
| wr_data_o | output | 8 | Data-port byte |

## Verification
The no-target pulse is due one cycle after the start is sampled. The bench reads done_o and result_o at the next falling edge, and checks that PROGRAM, enable and INIT hold did not move. A per-cycle monitor, sampling at falling edges, gives the other timing checks. It counts the cycles with PROGRAM low (expected PROG_LOW_CYC). It counts the cycles from the first one with PROGRAM high to the done pulse, which must equal INIT_LIMIT when INIT stays low. It also counts the cycles from the last strobe to the pulse, which must equal DONE_LIMIT when DONE stays low. Written bytes are captured in strobe order and compared with the pattern the stream source sent. A start is injected during the data phase, and the bench confirms that only one done pulse and one PROGRAM pulse follow.

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int SIZE_W       = 24,
  parameter int PROG_LOW_CYC = 20,
  parameter int INIT_LIMIT   = 10_000_000,
  parameter int DONE_LIMIT   = 100_000_000,
  parameter bit HAS_ENABLE   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              present_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        result_o,
  output logic              en_o,
  output logic              prog_n_o,
  output logic              init_hold_o,
  input  logic              init_i,
  input  logic              cfg_done_i,
  input  logic              s_valid_i,
  input  logic [7:0]        s_data_i,
  output logic              s_ready_o,
  output logic              wr_o,
  output logic [7:0]        wr_data_o
);
  localparam int MAX_A = (INIT_LIMIT > DONE_LIMIT) ? INIT_LIMIT : DONE_LIMIT;
  localparam int MAX_L = (MAX_A > PROG_LOW_CYC) ? MAX_A : PROG_LOW_CYC;
  localparam int TW    = $clog2(MAX_L + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_REL, S_PROG, S_WINIT, S_DATA, S_WDONE, S_FIN
  } st_t;

  st_t             st;
  logic [TW-1:0]   tmr;
  logic [SIZE_W-1:0] left;
  logic [1:0]      res;
  logic            hold;
  logic [1:0]      init_q, done_q;

  wire init_s = init_q[1];
  wire done_s = done_q[1];
  wire accept = s_valid_i && (st == S_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tmr    <= '0;
      left   <= '0;
      res    <= 2'd0;
      hold   <= 1'b1;
      init_q <= 2'b00;
      done_q <= 2'b00;
    end else begin
      init_q <= {init_q[0], init_i};
      done_q <= {done_q[0], cfg_done_i};
      case (st)
        S_IDLE: begin
          tmr <= '0;
          if (start_i) begin
            if (present_i) begin
              st   <= S_REL;
              left <= size_i;
              hold <= 1'b0;
            end else begin
              res <= 2'd1;
              st  <= S_FIN;
            end
          end
        end
        S_REL: begin
          st  <= S_PROG;
          tmr <= '0;
        end
        S_PROG: begin
          if (tmr == TW'(PROG_LOW_CYC - 1)) begin
            st  <= S_WINIT;
            tmr <= '0;
          end else tmr <= tmr + 1'b1;
        end
        S_WINIT: begin
          if (init_s) begin
            st  <= (left == '0) ? S_WDONE : S_DATA;
            tmr <= '0;
          end else if (tmr == TW'(INIT_LIMIT - 1)) begin
            res <= 2'd2;
            st  <= S_FIN;
          end else tmr <= tmr + 1'b1;
        end
        S_DATA: begin
          if (accept) begin
            left <= left - 1'b1;
            if (left == SIZE_W'(1)) begin
              st  <= S_WDONE;
              tmr <= '0;
            end
          end
        end
        S_WDONE: begin
          if (done_s) begin
            res <= 2'd0;
            st  <= S_FIN;
          end else if (tmr == TW'(DONE_LIMIT - 1)) begin
            res <= 2'd3;
            st  <= S_FIN;
          end else tmr <= tmr + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (st != S_IDLE);
  assign done_o      = (st == S_FIN);
  assign result_o    = res;
  assign en_o        = HAS_ENABLE && (st inside {S_REL, S_PROG, S_WINIT, S_DATA, S_WDONE});
  assign prog_n_o    = (st != S_PROG);
  assign init_hold_o = hold;
  assign s_ready_o   = (st == S_DATA);
  assign wr_o        = accept;
  assign wr_data_o   = s_data_i;
endmodule

module cfg_loader_chk #(
  parameter int PROG_LOW_CYC = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       present_i,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] result_o,
  input logic       en_o,
  input logic       prog_n_o,
  input logic       init_hold_o,
  input logic       wr_o
);
  logic [31:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else if (!prog_n_o) low_cnt <= low_cnt + 1'b1;
    else low_cnt <= '0;
  end

  p_no_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && !present_i |=> done_o && result_o == 2'd1);

  p_done_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);

  p_en_off_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !en_o);

  p_init_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n_o |-> !init_hold_o);

  p_prog_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_n_o) |-> low_cnt == PROG_LOW_CYC);

  p_wr_in_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> busy_o && prog_n_o && !init_hold_o);

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && busy_o && !done_o |=> busy_o);
endmodule

bind cfg_loader cfg_loader_chk #(.PROG_LOW_CYC(PROG_LOW_CYC)) chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .present_i(present_i),
  .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .en_o(en_o),
  .prog_n_o(prog_n_o), .init_hold_o(init_hold_o), .wr_o(wr_o)
);

// File: tb/cfg_loader_test.sv
module cfg_loader_test;
  localparam int SW = 16, PLC = 20, IL = 40, DL = 60;

  logic clk = 0, rst_n = 0;
  logic start = 0, present = 0, init_l = 0, done_l = 0;
  logic [SW-1:0] size = '0;
  logic s_valid = 0;
  logic [7:0] s_data = '0;
  logic busy, done, en, prog_n, hold, ready, wr;
  logic [1:0] result;
  logic [7:0] wdata;

  int checks = 0, fails = 0;

  cfg_loader #(.SIZE_W(SW), .PROG_LOW_CYC(PLC), .INIT_LIMIT(IL), .DONE_LIMIT(DL),
               .HAS_ENABLE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .present_i(present), .size_i(size),
    .busy_o(busy), .done_o(done), .result_o(result), .en_o(en), .prog_n_o(prog_n),
    .init_hold_o(hold), .init_i(init_l), .cfg_done_i(done_l), .s_valid_i(s_valid),
    .s_data_i(s_data), .s_ready_o(ready), .wr_o(wr), .wr_data_o(wdata));

  always #5 clk = ~clk;

  int n_wr, n_done, n_plow, n_prise, n_en, idx, n_exp, cyc;
  int t_prog, rec_prog, t_wr, rec_wr, n_rdy_late;
  bit run_prog, run_wr, prev_prog, src_on, en_at_done;
  logic [1:0] res_seen;
  logic [7:0] cap [0:63];

  function automatic logic [7:0] pat(int i);
    return 8'(i * 7 + 3);
  endfunction

  task automatic clear();
    n_wr = 0; n_done = 0; n_plow = 0; n_prise = 0; n_en = 0; idx = 0;
    run_prog = 0; run_wr = 0; rec_prog = -1; rec_wr = -1; n_rdy_late = 0;
    en_at_done = 0; res_seen = 2'bxx;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!prog_n) n_plow++;
    if (en) n_en++;
    if (ready && n_wr >= n_exp) n_rdy_late++;
    if (!prev_prog && prog_n) begin n_prise++; run_prog = 1; t_prog = 1; end
    else if (run_prog) begin
      if (done) begin rec_prog = t_prog; run_prog = 0; end else t_prog++;
    end
    if (wr) begin
      if (n_wr < 64) cap[n_wr] = wdata;
      n_wr++; idx++; run_wr = 1; t_wr = 0;
    end else if (run_wr) begin
      if (done) begin rec_wr = t_wr; run_wr = 0; end else t_wr++;
    end
    if (done) begin n_done++; res_seen = result; en_at_done = en; end
    prev_prog = prog_n;
  end

  always @(posedge clk) begin
    #1;
    s_valid = src_on && (idx < n_exp) && ((cyc % 4) != 2);
    s_data  = pat(idx);
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic go(bit pres, int n);
    @(posedge clk); #1;
    start = 1; present = pres; size = SW'(n); n_exp = n;
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic wait_done(int lim);
    int k = 0;
    while (n_done == 0 && k < lim) begin @(negedge clk); k++; end
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy && !done, "R2 reset busy/done", busy, 0);
    chk(prog_n && !en && !ready && !wr, "R5 reset pins", prog_n, 1);
    chk(hold, "R4 reset init hold", hold, 1);
  endtask

  task automatic t_no_target();
    clear();
    go(0, 5);
    @(negedge clk);
    chk(done, "R1 done next cycle", done, 1);
    chk(result == 2'd1, "R1 code", result, 1);
    @(negedge clk);
    chk(!busy, "R2 busy drops after pulse", busy, 0);
    chk(n_plow == 0 && n_en == 0, "R1 pins untouched", n_plow + n_en, 0);
    chk(hold, "R1 init hold unchanged", hold, 1);
  endtask

  task automatic load(int n, bit init_ok, bit done_ok, bit inject);
    clear();
    init_l = 0; done_l = 0; src_on = 1;
    go(1, n);
    @(negedge clk);
    chk(!hold && en && prog_n, "R4 release before program", hold, 0);
    if (init_ok) begin
      while (prog_n) @(negedge clk);
      while (!prog_n) @(negedge clk);
      repeat (5) @(negedge clk);
      init_l = 1;
      while (n_wr < n && n_done == 0) begin
        @(negedge clk);
        if (inject && n_wr == 2) begin
          @(posedge clk); #1 start = 1; present = 1; size = SW'(3);
          @(posedge clk); #1 start = 0;
        end
      end
      if (done_ok) begin repeat (3) @(negedge clk); done_l = 1; end
    end
    wait_done(IL + DL + 4 * n + 100);
    repeat (30) @(negedge clk);
    src_on = 0;
    chk(n_done == 1, "R2 one done pulse", n_done, 1);
    chk(n_plow == PLC, "R5 program low width", n_plow, PLC);
    chk(!en_at_done && !en, "R3 enable low at end", en, 0);
  endtask

  initial begin
    cyc = 0; prev_prog = 1; src_on = 0; n_exp = 0;
    clear();
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_no_target();

    load(12, 1, 1, 0);
    chk(res_seen == 2'd0, "R9 success code", res_seen, 0);
    chk(n_wr == 12, "R7 byte count", n_wr, 12);
    for (int i = 0; i < 12; i++)
      chk(cap[i] == pat(i), "R7 byte order", cap[i], pat(i));
    chk(n_rdy_late == 0, "R7 ready outside data phase", n_rdy_late, 0);
    chk(n_en > PLC, "R3 enable during load", n_en, PLC + 1);

    load(4, 0, 0, 0);
    chk(res_seen == 2'd2, "R6 INIT timeout code", res_seen, 2);
    chk(rec_prog == IL, "R6 INIT timeout timing", rec_prog, IL);
    chk(n_wr == 0, "R6 no writes", n_wr, 0);

    load(7, 1, 0, 0);
    chk(res_seen == 2'd3, "R8 DONE timeout code", res_seen, 3);
    chk(rec_wr == DL, "R8 DONE timeout timing", rec_wr, DL);
    chk(n_wr == 7, "R7 count before timeout", n_wr, 7);

    load(9, 1, 1, 1);
    chk(n_prise == 1, "R10 no second program pulse", n_prise, 1);
    chk(!busy, "R10 idle after load", busy, 0);
    chk(res_seen == 2'd0 && n_wr == 9, "R10 first load unchanged", n_wr, 9);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule